// File: doc/BRIEF.md
# Asynchronous Memory Cycle Engine

This block runs byte-wide accesses on an external asynchronous memory while the host already owns that bus. A single command on a valid/ready handshake selects one of three operations: a single-byte read, a single-byte write, or a fill burst that writes the same byte to a run of consecutive addresses. The engine sequences the active-low memory-request, read and write strobes and presents the address as two byte lanes plus a narrow top field. The data bus is modelled as separate output, input and output-enable signals.

Strobe widths are whole clock cycles, set by parameters. A fill burst holds memory-request low across every byte and gives one write pulse per byte. The address steps by one between pulses and only changes while both strobes are high. Read data comes back on its own port together with a one-cycle valid flag. Bus arbitration lies outside this block.

Top module: `amce_mem_engine`

## Requirements
- R1: After reset, and whenever `cmd_ready` is high, the engine holds `mem_mreq_n`, `mem_rd_n` and `mem_wr_n` high, `mem_dq_oe` low and `rd_valid` low.
- R2: The address is stable for at least one cycle with memory-request high before `mem_mreq_n` falls. A strobe is only low while `mem_mreq_n` is low. On a write, `mem_mreq_n` falls one cycle before `mem_wr_n` falls, and `mem_dq_oe` and `mem_dq_out` are valid from the fall of `mem_mreq_n`.
- R3: Every write pulse holds `mem_wr_n` low for exactly `WR_CYC` cycles (default 2).
- R4: After the last strobe of a command, the strobe returns high one cycle before `mem_mreq_n` returns high.
- R5: A read holds `mem_rd_n` low for exactly `RD_CYC` cycles (default 3) and gives exactly one read pulse per read command.
- R6: `rd_data` takes the value of `mem_dq_in` sampled in the last low cycle of `mem_rd_n`. `rd_valid` is high for exactly the one cycle in which `mem_rd_n` has just returned high.
- R7: A fill (`cmd_op` = 2) of length L ≥ 1 gives one fall of `mem_mreq_n` and L write pulses. Pulse k (k = 0..L-1) carries address (`cmd_addr` + k) modulo 2^19 and data `cmd_data`.
- R8: The address (`{mem_addr_top, mem_addr_hi, mem_addr_lo}`) never changes while `mem_wr_n` or `mem_rd_n` is low.
- R9: A fill of length 0 and the unused opcode 3 are accepted with no bus activity, and `cmd_ready` stays high in the next cycle. Opcode 0 is a read and opcode 1 is a single write; both ignore `cmd_len`.
- R10: `mem_dq_oe` is never high while `mem_rd_n` is low.
- R11: After acceptance, `cmd_ready` stays low for 4+`RD_CYC` cycles for a read, 4+`WR_CYC` cycles for a write, and 2+L·(`WR_CYC`+2) cycles for a fill of length L ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | 0 read, 1 write, 2 fill, 3 no operation |
| cmd_addr | input | 19 | Start address |
| cmd_data | input | 8 | Write or fill byte |
| cmd_len | input | 8 | Fill length in bytes |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| rd_data | output | 8 | Last byte read |
| mem_addr_lo | output | 8 | Address bits 7..0 |
| mem_addr_hi | output | 8 | Address bits 15..8 |
| mem_addr_top | output | 3 | Address bits 18..16 |
| mem_mreq_n | output | 1 | Memory request, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 8 | Data returned by memory |

## Verification
All bus outputs are registered. Counting from the accepting edge, memory-request falls in cycle 2 and the strobe falls in cycle 3. The strobe rises in cycle 3+`WR_CYC` or 3+`RD_CYC`, `rd_valid` appears in that same cycle for a read, and `cmd_ready` returns in cycle 5+width (3+L·(`WR_CYC`+2) for a fill). The scoreboard monitor samples on the falling clock edge. It compares each write event at the cycle its strobe is seen rising and each read result at the cycle `rd_valid` is seen. The driver counts ready-low cycles against those formulas.

// File: rtl/amce_pkg.sv
package amce_pkg;

    // Command opcodes as presented on cmd_op
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FILL  = 2'd2,
        OP_NOP   = 2'd3
    } op_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a command
        ST_SETUP,   // address out, request still high
        ST_MREQ,    // request low, data enabled for writes
        ST_STROBE,  // read or write strobe low
        ST_REL,     // strobe high again, request still low
        ST_NEXT,    // burst: next address out, request low
        ST_END      // request high, recovery cycle
    } st_e;

endpackage

// File: rtl/amce_strobe_timer.sv
module amce_strobe_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // final cycle of the strobe window
    assign last = (cnt_q == CNT_W'(1));

    // a new window is never loaded while the previous one is still running (R3)
    p_no_reload_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0 || cnt_q == CNT_W'(1) || last));

endmodule

// File: rtl/amce_burst_track.sv
module amce_burst_track #(
    parameter int ADDR_W = 19,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.addr   = load_addr;
            d.remain = load_len;
        end else if (step) begin
            d.addr   = q.addr + 1'b1;   // wraps over the full address space
            d.remain = q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr = q.addr;
    assign last = (q.remain == LEN_W'(1));

    // the sequencer only advances while bytes remain (R7)
    p_step_has_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (q.remain > LEN_W'(1)));

    // no load and advance in the same cycle (R7)
    p_load_step_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/amce_addr_lanes.sv
module amce_addr_lanes #(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [7:0]           lane_lo,
    output logic [7:0]           lane_hi,
    output logic [ADDR_W-17:0]   lane_top
);

    localparam int NLANE = 2;
    localparam int TOP_W = ADDR_W - 16;

    logic [NLANE-1:0][7:0] lanes;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign lanes[i] = addr[i*8 +: 8];
    end

    assign lane_lo  = lanes[0];
    assign lane_hi  = lanes[1];
    assign lane_top = addr[ADDR_W-1 -: TOP_W];

endmodule

// File: rtl/amce_mem_engine.sv
module amce_mem_engine
    import amce_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int WR_CYC = 2,
    parameter int RD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        mem_addr_lo,
    output logic [7:0]        mem_addr_hi,
    output logic [ADDR_W-17:0] mem_addr_top,
    output logic              mem_mreq_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int MAX_CYC = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int CHK_W   = CNT_W + 1;

    typedef struct packed {
        st_e               st;
        logic              is_read;
        logic              mreq_n;
        logic              rd_n;
        logic              wr_n;
        logic              oe;
        logic [DATA_W-1:0] dout;
        logic              rd_vld;
        logic [DATA_W-1:0] rd_dat;
    } ctl_t;

    ctl_t d, q;

    op_e               op;
    logic              trk_load, trk_step, trk_last;
    logic [LEN_W-1:0]  trk_len;
    logic [ADDR_W-1:0] trk_addr;
    logic              tmr_load, tmr_last;
    logic [CNT_W-1:0]  tmr_val;

    assign op = op_e'(cmd_op);

    // ------------------------------------------------------------------
    // next-state logic
    // ------------------------------------------------------------------
    always_comb begin
        d        = q;
        d.rd_vld = 1'b0;
        trk_load = 1'b0;
        trk_step = 1'b0;
        trk_len  = LEN_W'(1);
        tmr_load = 1'b0;
        tmr_val  = q.is_read ? CNT_W'(RD_CYC) : CNT_W'(WR_CYC);

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_READ: begin
                            d.is_read = 1'b1;
                            trk_load  = 1'b1;
                            d.st      = ST_SETUP;
                        end
                        OP_WRITE: begin
                            d.is_read = 1'b0;
                            d.dout    = cmd_data;
                            trk_load  = 1'b1;
                            d.st      = ST_SETUP;
                        end
                        OP_FILL: begin
                            if (cmd_len != '0) begin
                                d.is_read = 1'b0;
                                d.dout    = cmd_data;
                                trk_len   = cmd_len;
                                trk_load  = 1'b1;
                                d.st      = ST_SETUP;
                            end
                        end
                        default: ;  // no-operation: accepted, nothing driven
                    endcase
                end
            end
            ST_SETUP: begin
                d.mreq_n = 1'b0;
                d.oe     = !q.is_read;
                d.st     = ST_MREQ;
            end
            ST_MREQ: begin
                tmr_load = 1'b1;
                if (q.is_read) begin
                    d.rd_n = 1'b0;
                end else begin
                    d.wr_n = 1'b0;
                end
                d.st = ST_STROBE;
            end
            ST_STROBE: begin
                if (tmr_last) begin
                    d.rd_n = 1'b1;
                    d.wr_n = 1'b1;
                    d.st   = ST_REL;
                    if (q.is_read) begin
                        d.rd_vld = 1'b1;
                        d.rd_dat = mem_dq_in;
                    end
                end
            end
            ST_REL: begin
                if (!q.is_read && !trk_last) begin
                    trk_step = 1'b1;
                    d.st     = ST_NEXT;
                end else begin
                    d.mreq_n = 1'b1;
                    d.oe     = 1'b0;
                    d.st     = ST_END;
                end
            end
            ST_NEXT: begin
                tmr_load = 1'b1;
                d.wr_n   = 1'b0;
                d.st     = ST_STROBE;
            end
            ST_END: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.is_read <= 1'b0;
            q.mreq_n  <= 1'b1;
            q.rd_n    <= 1'b1;
            q.wr_n    <= 1'b1;
            q.oe      <= 1'b0;
            q.dout    <= '0;
            q.rd_vld  <= 1'b0;
            q.rd_dat  <= '0;
        end else begin
            q <= d;
        end
    end

    // ------------------------------------------------------------------
    // sub-blocks
    // ------------------------------------------------------------------
    amce_strobe_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    amce_burst_track #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_addr (cmd_addr),
        .load_len  (trk_len),
        .step      (trk_step),
        .addr      (trk_addr),
        .last      (trk_last)
    );

    amce_addr_lanes #(
        .ADDR_W (ADDR_W)
    ) u_lanes (
        .addr     (trk_addr),
        .lane_lo  (mem_addr_lo),
        .lane_hi  (mem_addr_hi),
        .lane_top (mem_addr_top)
    );

    assign cmd_ready  = (q.st == ST_IDLE);
    assign rd_valid   = q.rd_vld;
    assign rd_data    = q.rd_dat;
    assign mem_mreq_n = q.mreq_n;
    assign mem_rd_n   = q.rd_n;
    assign mem_wr_n   = q.wr_n;
    assign mem_dq_out = q.dout;
    assign mem_dq_oe  = q.oe;

    // ------------------------------------------------------------------
    // strobe-width observers feeding the assertions below
    // ------------------------------------------------------------------
    logic [CHK_W-1:0] wr_low_q, rd_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_low_q <= '0;
            rd_low_q <= '0;
        end else begin
            wr_low_q <= !q.wr_n ? ((wr_low_q == '1) ? wr_low_q : wr_low_q + 1'b1) : '0;
            rd_low_q <= !q.rd_n ? ((rd_low_q == '1) ? rd_low_q : rd_low_q + 1'b1) : '0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (q.mreq_n && q.rd_n && q.wr_n && !q.oe));

    p_strobe_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.wr_n || !q.rd_n) |-> !q.mreq_n);

    p_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.mreq_n) |-> ($stable(trk_addr) && q.wr_n && q.rd_n));

    p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wr_n) |-> (wr_low_q == CHK_W'(WR_CYC)));

    p_strobe_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.mreq_n) |-> ($past(q.wr_n) && $past(q.rd_n)));

    p_rd_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rd_n) |-> (rd_low_q == CHK_W'(RD_CYC)));

    p_rd_valid_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_vld |-> $rose(q.rd_n));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!q.wr_n && !$past(q.wr_n)) || (!q.rd_n && !$past(q.rd_n))) |-> $stable(trk_addr));

    p_no_oe_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rd_n |-> !q.oe);

    p_busy_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op == OP_WRITE) |=> !cmd_ready);

endmodule

// File: tb/amce_mem_engine_test.sv
module amce_mem_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int WR = 2;
    localparam int RD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [7:0]  cmd_len = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [7:0]  mem_addr_lo, mem_addr_hi;
    logic [2:0]  mem_addr_top;
    logic        mem_mreq_n, mem_rd_n, mem_wr_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amce_mem_engine uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr_lo(mem_addr_lo), .mem_addr_hi(mem_addr_hi), .mem_addr_top(mem_addr_top),
        .mem_mreq_n(mem_mreq_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [7:0] pat(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    wire [18:0] bus_addr = {mem_addr_top, mem_addr_hi, mem_addr_lo};

    // memory model: returns a pattern of the address while read is low
    assign mem_dq_in = !mem_rd_n ? pat(bus_addr) : 8'h00;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic [26:0] exp_wr_q[$];
    logic [7:0]  exp_rd_q[$];

    // monitor state
    logic [18:0] p_addr = '0;
    logic p_mreq = 1'b1, p_wr = 1'b1, p_rd = 1'b1;
    int wr_lo = 0, rd_lo = 0;
    int n_falls = 0, n_wr = 0, n_rd = 0;
    int v_r2 = 0, v_r4 = 0, v_r8 = 0, v_r10 = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_mreq_n && p_mreq) begin
                n_falls++;
                if (!(mem_wr_n && mem_rd_n) || bus_addr != p_addr) v_r2++;
            end
            if (!mem_wr_n && p_wr && (p_mreq || !mem_dq_oe)) v_r2++;
            if ((!mem_wr_n || !mem_rd_n) && mem_mreq_n) v_r2++;
            if (mem_mreq_n && !p_mreq && (!p_wr || !p_rd)) v_r4++;
            if (((!mem_wr_n && !p_wr) || (!mem_rd_n && !p_rd)) && bus_addr != p_addr) v_r8++;
            if (!mem_rd_n && mem_dq_oe) v_r10++;

            if (!mem_wr_n) wr_lo++;
            if (mem_wr_n && !p_wr) begin
                n_wr++;
                chk("R3 write low cycles", wr_lo, WR);
                chk("R4 request still low at write rise", int'(mem_mreq_n), 0);
                if (exp_wr_q.size() == 0) begin
                    chk("R7 unexpected write event", 1, 0);
                end else begin
                    logic [26:0] e;
                    e = exp_wr_q.pop_front();
                    chk("R7 write address", int'(p_addr), int'(e[26:8]));
                    chk("R2 write data", int'(mem_dq_out), int'(e[7:0]));
                end
                wr_lo = 0;
            end

            if (!mem_rd_n) rd_lo++;
            if (mem_rd_n && !p_rd) begin
                n_rd++;
                chk("R5 read low cycles", rd_lo, RD);
                rd_lo = 0;
            end

            if (rd_valid) begin
                chk("R6 valid in cycle read rises", int'(mem_rd_n && !p_rd), 1);
                if (exp_rd_q.size() == 0) begin
                    chk("R6 unexpected read result", 1, 0);
                end else begin
                    chk("R6 read data", int'(rd_data), int'(exp_rd_q.pop_front()));
                end
            end

            p_addr = bus_addr;
            p_mreq = mem_mreq_n;
            p_wr   = mem_wr_n;
            p_rd   = mem_rd_n;
        end
    end

    // driver: pushes expectations, issues one command, times completion
    task automatic issue(input logic [1:0] op, input logic [18:0] a,
                         input logic [7:0] dat, input logic [7:0] len);
        int exp_busy, exp_wr, exp_rd, exp_falls, busy;
        exp_busy = 0; exp_wr = 0; exp_rd = 0;
        case (op)
            2'd0: begin exp_busy = 4 + RD; exp_rd = 1; exp_rd_q.push_back(pat(a)); end
            2'd1: begin exp_busy = 4 + WR; exp_wr = 1; exp_wr_q.push_back({a, dat}); end
            2'd2: begin
                if (len != 0) exp_busy = 2 + int'(len) * (WR + 2);
                exp_wr = int'(len);
                for (int k = 0; k < int'(len); k++) begin
                    logic [18:0] ak;
                    ak = a + 19'(k);
                    exp_wr_q.push_back({ak, dat});
                end
            end
            default: ;
        endcase
        exp_falls = (exp_wr + exp_rd > 0) ? 1 : 0;

        @(negedge clk);
        n_falls = 0; n_wr = 0; n_rd = 0; v_r2 = 0; v_r4 = 0; v_r8 = 0; v_r10 = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = dat; cmd_len = len;
        @(posedge clk);
        busy = 0;
        forever begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (cmd_ready) break;
            busy++;
            if (busy > 5000) break;
        end
        #1;
        chk("R11 ready-low cycles", busy, exp_busy);
        chk("R7 request falls per command", n_falls, exp_falls);
        chk("R7 write pulses per command", n_wr, exp_wr);
        chk("R5 read pulses per command", n_rd, exp_rd);
        chk("R2 ordering violations", v_r2, 0);
        chk("R4 request before strobe violations", v_r4, 0);
        chk("R8 address moved under strobe", v_r8, 0);
        chk("R10 enable during read", v_r10, 0);
        chk("R1 idle request high", int'(mem_mreq_n), 1);
        chk("R1 idle enable low", int'(mem_dq_oe), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready after reset", int'(cmd_ready), 1);
        chk("R1 request high", int'(mem_mreq_n), 1);
        chk("R1 read high", int'(mem_rd_n), 1);
        chk("R1 write high", int'(mem_wr_n), 1);
        chk("R1 enable low", int'(mem_dq_oe), 0);
        chk("R1 no valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(2'd1, 19'h12345, 8'hC3, 8'd9);   // single write, length ignored (R9)
        issue(2'd0, 19'h7FFFF, 8'h00, 8'd0);   // read at top address
        issue(2'd0, 19'h00000, 8'h00, 8'd0);   // read at bottom address
        issue(2'd1, 19'h40001, 8'h00, 8'd0);
        issue(2'd1, 19'h3FFFF, 8'hFF, 8'd0);
        issue(2'd2, 19'h7FFFE, 8'hA5, 8'd4);   // fill wrapping over the top (R7)
        issue(2'd2, 19'h01234, 8'h3C, 8'd1);
        issue(2'd2, 19'h05555, 8'h77, 8'd0);   // R9: zero-length fill
        issue(2'd3, 19'h0AAAA, 8'h11, 8'd5);   // R9: no-operation opcode
        issue(2'd2, 19'h2A0F0, 8'h96, 8'd20);
        issue(2'd0, 19'h2A0F5, 8'h00, 8'd3);

        chk("R7 write queue drained", exp_wr_q.size(), 0);
        chk("R6 read queue drained", exp_rd_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule